// File: doc/BRIEF.md
# Masked Control Register Bank

This block is a bank of 16-bit control registers that sits on a plain processor bus. A write carries a byte address, 16 bits of data, a write strobe and a size flag that marks a single-byte write. A read carries a read strobe and returns 16 bits of data. Each register keeps only the bits its write mask allows. Some locations only return a value, some only accept writes, and some return a fixed zero. The video, sound, transfer and timer engines behind the registers are not part of the block. Their settings are held here only as stored fields.

A group of sound channel registers is tied to a master sound enable bit. While that bit is clear, the group ignores writes and reads back as zero. Single-byte writes are merged into the addressed halfword, and the merged value then goes through the normal masked write path. Reads of locations that hold no readable value return an open-bus word supplied on an input. Read data is registered and appears one cycle after the read strobe.

Top module: `ctl_regbank`

## Requirements
- R1: With `bus_byte` high, the byte on `bus_wdata[7:0]` goes into bits 15:8 of the halfword when `bus_addr[0]` is 1, or into bits 7:0 when `bus_addr[0]` is 0. The other byte of the halfword keeps its stored value, and the merged word then passes through the register's write mask.
- R2: Stored bits follow each register's write mask. The masks are: display status at 0x02 uses 0xFFF8, timer control at 0x30 uses 0x00C7, wait control at 0x50 uses 0x5FFF, key interrupt control at 0x44 uses 0xC3FF, and serial mode at 0x40 uses 0xC1FF.
- R3: The line count at 0x04 reads as `scan_line`, zero-extended to 16 bits. Writes to it have no effect.
- R4: While bit 7 of the sound master register is 0, writes to the channel group at 0x10, 0x12, 0x14 and 0x16 (the last one is the mixer-low register) are dropped. While that bit is 1, they are stored.
- R5: While bit 7 of the sound master register is 0, reads of the channel group return 0x0000. The stored contents reappear once the bit is set again.
- R6: The sound master register at 0x1A stores only bit 7 of a write. Bits 3:0 read back as `chan_active`, and every other bit reads as 0.
- R7: The write-only locations return `open_bus` when read. These are scroll 0x06, window 0x08, the affine parameters 0x0A and 0x0C, and the transfer source words 0x20 and 0x22. Any unmapped address also returns `open_bus`.
- R8: After reset, the following values apply: display control at 0x00 is 0x0080, key input at 0x42 is 0x03FF, sound bias at 0x1C is 0x0200, and `bus_rdata` is 0x0000.
- R9: The transfer count-low word at 0x24 always reads 0x0000.
- R10: `bus_rdata` takes the addressed value at the clock edge where `bus_ren` is high. It holds that value while `bus_ren` is low.
- R11: Key input at 0x42 is read-only. Writes leave it at 0x03FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_wen | input | 1 | Write strobe |
| bus_byte | input | 1 | Marks the write as a single byte |
| bus_ren | input | 1 | Read strobe |
| open_bus | input | 16 | Value returned for unreadable locations |
| scan_line | input | 8 | Live line count shown at 0x04 |
| chan_active | input | 4 | Channel status shown in master bits 3:0 |
| bus_rdata | output | 16 | Registered read data |

## Verification
The properties assume a write and a read are never issued in the same cycle. They also assume `bus_byte` is only meaningful while `bus_wen` is high. The open-bus, line-count and status inputs are taken to be stable for the cycle in which a read is sampled. The bench follows all of these rules. It drives exactly one strobe per operation at the falling edge and keeps `open_bus`, `scan_line` and `chan_active` constant around each read.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  localparam int DATA_W = 16;

  // halfword indices (byte address >> 1)
  localparam int HW_DISP_CTRL  = 0;
  localparam int HW_DISP_STAT  = 1;
  localparam int HW_LINE       = 2;
  localparam int HW_SCROLL     = 3;
  localparam int HW_WIN_H      = 4;
  localparam int HW_AFF_PA     = 5;
  localparam int HW_AFF_PD     = 6;
  localparam int HW_SND_A      = 8;
  localparam int HW_SND_B      = 9;
  localparam int HW_SND_C      = 10;
  localparam int HW_SND_MIXLO  = 11;
  localparam int HW_SND_MIXHI  = 12;
  localparam int HW_SND_MASTER = 13;
  localparam int HW_SND_BIAS   = 14;
  localparam int HW_XFER_SRCL  = 16;
  localparam int HW_XFER_SRCH  = 17;
  localparam int HW_XFER_CNTL  = 18;
  localparam int HW_XFER_CNTH  = 19;
  localparam int HW_TMR_CTRL   = 24;
  localparam int HW_SER_MODE   = 32;
  localparam int HW_KEY_IN     = 33;
  localparam int HW_KEY_IRQ    = 34;
  localparam int HW_WAIT_CTRL  = 40;

  localparam int SND_EN_BIT    = 7;

  function automatic logic is_mapped(input int idx);
    case (idx)
      HW_DISP_CTRL, HW_DISP_STAT, HW_LINE, HW_SCROLL, HW_WIN_H,
      HW_AFF_PA, HW_AFF_PD, HW_SND_A, HW_SND_B, HW_SND_C,
      HW_SND_MIXLO, HW_SND_MIXHI, HW_SND_MASTER, HW_SND_BIAS,
      HW_XFER_SRCL, HW_XFER_SRCH, HW_XFER_CNTL, HW_XFER_CNTH,
      HW_TMR_CTRL, HW_SER_MODE, HW_KEY_IN, HW_KEY_IRQ,
      HW_WAIT_CTRL: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  // bits a write may change
  function automatic logic [DATA_W-1:0] wr_mask(input int idx);
    case (idx)
      HW_DISP_STAT:  return 16'hFFF8;
      HW_LINE:       return 16'h0000;
      HW_SND_MASTER: return 16'h0080;
      HW_SND_BIAS:   return 16'h3FFF;
      HW_XFER_CNTL:  return 16'h3FFF;
      HW_TMR_CTRL:   return 16'h00C7;
      HW_SER_MODE:   return 16'hC1FF;
      HW_KEY_IN:     return 16'h0000;
      HW_KEY_IRQ:    return 16'hC3FF;
      HW_WAIT_CTRL:  return 16'h5FFF;
      default:       return is_mapped(idx) ? 16'hFFFF : 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rst_value(input int idx);
    case (idx)
      HW_DISP_CTRL: return 16'h0080;
      HW_AFF_PA:    return 16'h0100;
      HW_AFF_PD:    return 16'h0100;
      HW_SND_BIAS:  return 16'h0200;
      HW_KEY_IN:    return 16'h03FF;
      default:      return 16'h0000;
    endcase
  endfunction

  function automatic logic is_write_only(input int idx);
    case (idx)
      HW_SCROLL, HW_WIN_H, HW_AFF_PA, HW_AFF_PD,
      HW_XFER_SRCL, HW_XFER_SRCH: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  function automatic logic reads_zero(input int idx);
    return idx == HW_XFER_CNTL;
  endfunction

  // channel group gated by the master enable (ordered range ending at mixer-low)
  function automatic logic is_gated(input int idx);
    return (idx >= HW_SND_A) && (idx <= HW_SND_MIXLO);
  endfunction

  function automatic logic has_storage(input int idx);
    return is_mapped(idx) && (idx != HW_LINE);
  endfunction

  function automatic logic [DATA_W-1:0] merge_byte(
    input logic [DATA_W-1:0] cur,
    input logic [7:0]        byte_in,
    input logic              upper
  );
    return upper ? {byte_in, cur[7:0]} : {cur[15:8], byte_in};
  endfunction

  function automatic logic [DATA_W-1:0] apply_mask(
    input logic [DATA_W-1:0] old_q,
    input logic [DATA_W-1:0] wd,
    input logic [DATA_W-1:0] mask
  );
    return (old_q & ~mask) | (wd & mask);
  endfunction

endpackage

// File: rtl/ctl_byte_merge.sv
module ctl_byte_merge
  import ctl_regbank_pkg::*;
(
  input  logic [DATA_W-1:0] cur_q,
  input  logic [DATA_W-1:0] wdata,
  input  logic              byte_en,
  input  logic              upper,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    if (byte_en) merged = merge_byte(cur_q, wdata[7:0], upper);
    else         merged = wdata;
  end
endmodule

// File: rtl/ctl_reg_cell.sv
module ctl_reg_cell
  import ctl_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = 16'hFFFF,
  parameter logic [DATA_W-1:0] RST  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= apply_mask(q, wd, MASK);
  end
endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux
  import ctl_regbank_pkg::*;
#(
  parameter int HW_W   = 6,
  parameter int LINE_W = 8,
  parameter int STAT_W = 4
) (
  input  logic [HW_W-1:0]   idx,
  input  logic [DATA_W-1:0] sel_q,
  input  logic [DATA_W-1:0] open_bus,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [STAT_W-1:0] chan_active,
  input  logic              snd_en,
  output logic [DATA_W-1:0] rd_val
);
  int i;
  always_comb begin
    i = int'(idx);
    if (!is_mapped(i) || is_write_only(i))  rd_val = open_bus;
    else if (reads_zero(i))                 rd_val = '0;
    else if (is_gated(i) && !snd_en)        rd_val = '0;
    else if (i == HW_LINE)                  rd_val = DATA_W'(scan_line);
    else if (i == HW_SND_MASTER)
      rd_val = {sel_q[DATA_W-1:STAT_W], chan_active};
    else                                    rd_val = sel_q;
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LINE_W = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wen,
  input  logic              bus_byte,
  input  logic              bus_ren,
  input  logic [15:0]       open_bus,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [STAT_W-1:0] chan_active,
  output logic [15:0]       bus_rdata
);
  localparam int HW_W   = ADDR_W - 1;
  localparam int NUM_HW = 1 << HW_W;

  logic [HW_W-1:0]   hw_idx;
  logic [DATA_W-1:0] hw_q [NUM_HW];
  logic [DATA_W-1:0] cur_q;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] rd_val;
  logic              snd_en;
  logic              gate_hit;
  logic              wr_fire;
  logic [4*DATA_W-1:0] snd_vec;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] tmr_q;
  logic [DATA_W-1:0] key_q;

  assign hw_idx   = bus_addr[ADDR_W-1:1];
  assign cur_q    = hw_q[hw_idx];
  assign snd_en   = hw_q[HW_SND_MASTER][SND_EN_BIT];
  assign gate_hit = is_gated(int'(hw_idx));
  assign wr_fire  = bus_wen && !(gate_hit && !snd_en);

  // named taps for the checker
  assign snd_vec = {hw_q[HW_SND_A], hw_q[HW_SND_B], hw_q[HW_SND_C], hw_q[HW_SND_MIXLO]};
  assign stat_q  = hw_q[HW_DISP_STAT];
  assign tmr_q   = hw_q[HW_TMR_CTRL];
  assign key_q   = hw_q[HW_KEY_IN];

  ctl_byte_merge u_merge (
    .cur_q   (cur_q),
    .wdata   (bus_wdata),
    .byte_en (bus_byte),
    .upper   (bus_addr[0]),
    .merged  (wr_word)
  );

  for (genvar g = 0; g < NUM_HW; g++) begin : g_cell
    if (has_storage(g)) begin : g_reg
      ctl_reg_cell #(
        .MASK (wr_mask(g)),
        .RST  (rst_value(g))
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire && (hw_idx == HW_W'(g))),
        .wd    (wr_word),
        .q     (hw_q[g])
      );
    end else begin : g_none
      assign hw_q[g] = '0;
    end
  end

  ctl_read_mux #(
    .HW_W   (HW_W),
    .LINE_W (LINE_W),
    .STAT_W (STAT_W)
  ) u_rmux (
    .idx         (hw_idx),
    .sel_q       (cur_q),
    .open_bus    (open_bus),
    .scan_line   (scan_line),
    .chan_active (chan_active),
    .snd_en      (snd_en),
    .rd_val      (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LINE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic              bus_ren,
  input logic [15:0]       open_bus,
  input logic [LINE_W-1:0] scan_line,
  input logic [15:0]       bus_rdata,
  input logic              snd_en,
  input logic [63:0]       snd_vec,
  input logic [15:0]       stat_q,
  input logic [15:0]       tmr_q,
  input logic [15:0]       key_q
);
  int idx;
  assign idx = int'(bus_addr[ADDR_W-1:1]);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ren |=> $stable(bus_rdata)); // R10

  AST_LINE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && idx == HW_LINE) |=> bus_rdata == 16'($past(scan_line))); // R3

  AST_GATED_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && is_gated(idx) && !snd_en) |=> $stable(snd_vec)); // R4

  AST_GATED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && is_gated(idx) && !snd_en) |=> bus_rdata == 16'h0000); // R5

  AST_WO_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && is_write_only(idx)) |=> bus_rdata == $past(open_bus)); // R7

  AST_XFER_CNTL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && idx == HW_XFER_CNTL) |=> bus_rdata == 16'h0000); // R9

  AST_STAT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && idx == HW_DISP_STAT) |=> stat_q[2:0] == $past(stat_q[2:0])); // R2

  AST_TMR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q & 16'hFF38) == 16'h0000); // R2

  AST_KEY_IN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(key_q)); // R11
endmodule

bind ctl_regbank ctl_regbank_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_ren   (bus_ren),
  .open_bus  (open_bus),
  .scan_line (scan_line),
  .bus_rdata (bus_rdata),
  .snd_en    (snd_en),
  .snd_vec   (snd_vec),
  .stat_q    (stat_q),
  .tmr_q     (tmr_q),
  .key_q     (key_q)
);

// File: tb/ctl_regbank_tb.sv
`timescale 1ns/1ps
module ctl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wen = 1'b0;
  logic        bus_byte = 1'b0;
  logic        bus_ren = 1'b0;
  logic [15:0] open_bus = 16'hDEAD;
  logic [7:0]  scan_line = 8'h5A;
  logic [3:0]  chan_active = 4'hA;
  logic [15:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ctl_regbank u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wen (bus_wen), .bus_byte (bus_byte), .bus_ren (bus_ren),
    .open_bus (open_bus), .scan_line (scan_line), .chan_active (chan_active),
    .bus_rdata (bus_rdata)
  );

  // op: 0 word write, 1 byte write, 2 read-and-compare (data = expected)
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [6:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 4'd8,  7'h00, 16'h0080},  // R8 display control reset
    '{2'd2, 4'd8,  7'h42, 16'h03FF},  // R8 key input reset
    '{2'd2, 4'd8,  7'h1C, 16'h0200},  // R8 sound bias reset
    '{2'd0, 4'd2,  7'h02, 16'hFFFF},
    '{2'd2, 4'd2,  7'h02, 16'hFFF8},  // R2 display status
    '{2'd0, 4'd2,  7'h30, 16'hFFFF},
    '{2'd2, 4'd2,  7'h30, 16'h00C7},  // R2 timer
    '{2'd0, 4'd2,  7'h50, 16'hFFFF},
    '{2'd2, 4'd2,  7'h50, 16'h5FFF},  // R2 wait
    '{2'd0, 4'd2,  7'h44, 16'hFFFF},
    '{2'd2, 4'd2,  7'h44, 16'hC3FF},  // R2 key irq
    '{2'd0, 4'd2,  7'h40, 16'hFFFF},
    '{2'd2, 4'd2,  7'h40, 16'hC1FF},  // R2 serial
    '{2'd0, 4'd3,  7'h04, 16'h1234},
    '{2'd2, 4'd3,  7'h04, 16'h005A},  // R3 line count
    '{2'd0, 4'd11, 7'h42, 16'h0000},
    '{2'd2, 4'd11, 7'h42, 16'h03FF},  // R11 key input read-only
    '{2'd0, 4'd4,  7'h10, 16'h1111},  // R4 dropped while disabled
    '{2'd2, 4'd5,  7'h10, 16'h0000},  // R5 gated read zero
    '{2'd2, 4'd7,  7'h06, 16'hDEAD},  // R7 write-only
    '{2'd0, 4'd7,  7'h06, 16'h4321},
    '{2'd2, 4'd7,  7'h06, 16'hDEAD},
    '{2'd2, 4'd7,  7'h0A, 16'hDEAD},
    '{2'd2, 4'd7,  7'h22, 16'hDEAD},
    '{2'd2, 4'd7,  7'h78, 16'hDEAD},  // R7 unmapped
    '{2'd0, 4'd9,  7'h24, 16'hFFFF},
    '{2'd2, 4'd9,  7'h24, 16'h0000},  // R9
    '{2'd0, 4'd6,  7'h1A, 16'hFFFF},
    '{2'd2, 4'd6,  7'h1A, 16'h008A},  // R6 master
    '{2'd2, 4'd4,  7'h10, 16'h0000},  // R4 earlier write dropped
    '{2'd0, 4'd4,  7'h10, 16'h1111},
    '{2'd2, 4'd4,  7'h10, 16'h1111},  // R4 stored when enabled
    '{2'd0, 4'd4,  7'h16, 16'h2222},
    '{2'd2, 4'd4,  7'h16, 16'h2222},  // R4 mixer-low
    '{2'd1, 4'd1,  7'h01, 16'h00AB},
    '{2'd2, 4'd1,  7'h00, 16'hAB80},  // R1 upper lane
    '{2'd1, 4'd1,  7'h00, 16'h00CD},
    '{2'd2, 4'd1,  7'h00, 16'hABCD},  // R1 lower lane
    '{2'd1, 4'd1,  7'h31, 16'h00FF},
    '{2'd2, 4'd1,  7'h30, 16'h00C7},  // R1 merged then masked
    '{2'd0, 4'd5,  7'h1A, 16'h0000},
    '{2'd2, 4'd5,  7'h16, 16'h0000},  // R5 disabled again
    '{2'd0, 4'd5,  7'h1A, 16'h0080},
    '{2'd2, 4'd5,  7'h16, 16'h2222}   // R5 contents reappear
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input logic is_byte);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_byte = is_byte; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    check("R8 rdata after reset", bus_rdata, 16'h0000);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].op == 2'd2) begin
        do_read(VEC[k].addr, rd);
        check($sformatf("R%0d vec%0d addr %h", VEC[k].req, k, VEC[k].addr), rd, VEC[k].data);
      end else begin
        do_write(VEC[k].addr, VEC[k].data, VEC[k].op == 2'd1);
      end
    end

    // R10: rdata holds with no read strobe while the source changes
    do_read(7'h04, rd);
    check("R10 line read", rd, 16'h005A);
    scan_line = 8'h33;
    open_bus  = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R10 hold without read", bus_rdata, 16'h005A);
    do_read(7'h04, rd);
    check("R3 live line value", rd, 16'h0033);
    do_read(7'h08, rd);
    check("R7 new open bus", rd, 16'hBEEF);

    // R6: status bits follow the input, not the write
    chan_active = 4'h5;
    do_write(7'h1A, 16'h000F, 1'b0);
    do_read(7'h1A, rd);
    check("R6 status only", rd, 16'h0005);

    // R8: reset in mid-run restores values
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 rdata cleared", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    do_read(7'h00, rd);
    check("R8 display control after reset", rd, 16'h0080);
    do_read(7'h44, rd);
    check("R2 key irq cleared by reset", rd, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule